// File: doc/BRIEF.md
# Outstanding Memory Request Tracker

This block sits between a processor-side request port and a cache controller. It keeps a record of every memory request in flight, keyed by cache-line address. Read-class and write-class requests are held in two separate small associative tables. Each table entry has a valid bit, a line tag and an age counter.

Each presented request is first mapped to a primary and a secondary request type. The tracker then does one of four things: it issues the request, refuses it as aliased with a live line, refuses it because the tracker is full, or flags the access type as unsupported. The result comes back one cycle later on a registered response port. A completion names a line and a table. It frees the matching entry, and it raises an error pulse when no entry matches. An age watchdog raises a deadlock flag once any live entry has waited for the configured number of cycles.

The outstanding limit `MAX_OUT` must not exceed the table depth `DEPTH`. With that rule, a table can never run out of slots before the global limit is reached.

Top module: `mem_req_tracker`

## Requirements
- R1: After a synchronous reset, the tables are empty. The outstanding count is 0, the alias counters are 0, and `rsp_valid`, `deadlock` and `cpl_err` are low.
- R2: When the outstanding count is at or above `MAX_OUT`, a request gets status FULL (2) and nothing is inserted. This check takes precedence over the type and alias checks.
- R3: A write-class request (primary ST, RMW_RD, LL, SC, LRMW_RD, LRMW_WR or FLUSH) whose line is live in the read table gets status ALIASED (1). It also increments `cnt_st_on_ld`.
- R4: A write-class request whose line is live in the write table, and not in the read table, gets ALIASED. It increments `cnt_st_on_st`.
- R5: A read-class request (primary LD or IFETCH) gets ALIASED when its line is live in either table. A write-table hit increments `cnt_ld_on_st`. Otherwise a read-table hit increments `cnt_ld_on_ld`.
- R6: An accepted request gets status ISSUED (0). It is inserted into its class table, and the count rises by one. The line address is `req_addr` with its low log2(`LINE_BYTES`) bits ignored.
- R7: Classification of atomic accesses:
  - With `req_llsc` set, the primary type is SC (6) if `req_wr` is set and LL (5) otherwise, and the secondary type is ATOMIC (10).
  - Otherwise, with `req_locked` set, the primary type is LRMW_WR (8) if `req_wr` is set and LRMW_RD (7) otherwise, and the secondary type is ST (2).
- R8: Classification of plain accesses:
  - A read gives IFETCH (3/3) when `req_ifetch` is set. Otherwise it gives RMW_RD (4) with secondary ST (2) when `req_stchk` is set, and LD (1/1) when neither is set.
  - Failing a read, a write gives ST (2/2).
  - Failing both, a flush gives FLUSH (9/9).
  - Anything else gives status BADTYPE (3) with types NONE (0).
- R9: A completion frees the entry with the matching line in the table chosen by `cpl_write` (1 = write table), and the count drops by one. A completion that matches no entry raises `cpl_err` for one cycle.
- R10: `deadlock` is high while any live entry has been resident for `AGE_LIMIT` or more clock edges since its insertion edge.
- R11: The outstanding count always equals the number of valid entries across both tables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request presented this cycle |
| req_addr | input | ADDR_W | Byte address of the request |
| req_rd | input | 1 | Access reads |
| req_wr | input | 1 | Access writes |
| req_flush | input | 1 | Access is a line flush |
| req_llsc | input | 1 | Load-linked / store-conditional access |
| req_locked | input | 1 | Locked read-modify-write access |
| req_ifetch | input | 1 | Read is an instruction fetch |
| req_stchk | input | 1 | Read carries a store-check hint |
| cpl_valid | input | 1 | Completion presented this cycle |
| cpl_write | input | 1 | Completion targets the write table |
| cpl_addr | input | ADDR_W | Byte address of the completed line |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_status | output | 2 | 0 ISSUED, 1 ALIASED, 2 FULL, 3 BADTYPE |
| rsp_primary | output | 4 | Primary request type code |
| rsp_secondary | output | 4 | Secondary request type code |
| outstanding | output | $clog2(MAX_OUT+1) | Live entries in both tables |
| deadlock | output | 1 | An entry has reached the age limit |
| cpl_err | output | 1 | Previous completion matched no entry |
| cnt_st_on_ld | output | CNT_W | Write-class refused behind a read (saturating) |
| cnt_st_on_st | output | CNT_W | Write-class refused behind a write (saturating) |
| cnt_ld_on_st | output | CNT_W | Read-class refused behind a write (saturating) |
| cnt_ld_on_ld | output | CNT_W | Read-class refused behind a read (saturating) |

## Verification
A stale or lost valid bit shows up at the ports one cycle after the next request to that line. The request is issued where it should be aliased, or the reverse, and the alias counters move. The matching completion raises `cpl_err` one cycle after it is presented. A count that drifts from the tables shows up as a FULL response arriving too early or too late, and in the `outstanding` value on the cycle after each request or completion. A wrong age counter moves the `deadlock` edge off cycle `AGE_LIMIT` after insertion, so the bench samples that flag on both sides of the boundary.

// File: rtl/trk_pkg.sv
package trk_pkg;
  localparam logic [3:0] RT_NONE    = 4'd0;
  localparam logic [3:0] RT_LD      = 4'd1;
  localparam logic [3:0] RT_ST      = 4'd2;
  localparam logic [3:0] RT_IFETCH  = 4'd3;
  localparam logic [3:0] RT_RMW_RD  = 4'd4;
  localparam logic [3:0] RT_LL      = 4'd5;
  localparam logic [3:0] RT_SC      = 4'd6;
  localparam logic [3:0] RT_LRMW_RD = 4'd7;
  localparam logic [3:0] RT_LRMW_WR = 4'd8;
  localparam logic [3:0] RT_FLUSH   = 4'd9;
  localparam logic [3:0] RT_ATOMIC  = 4'd10;

  localparam logic [1:0] SS_ISSUED  = 2'd0;
  localparam logic [1:0] SS_ALIASED = 2'd1;
  localparam logic [1:0] SS_FULL    = 2'd2;
  localparam logic [1:0] SS_BADTYPE = 2'd3;

  function automatic logic is_read_class(input logic [3:0] t);
    return (t == RT_LD) || (t == RT_IFETCH);
  endfunction
endpackage

// File: rtl/req_classifier.sv
module req_classifier
  import trk_pkg::*;
(
  input  logic       rd,
  input  logic       wr,
  input  logic       flush,
  input  logic       llsc,
  input  logic       locked,
  input  logic       ifetch,
  input  logic       stchk,
  output logic [3:0] primary,
  output logic [3:0] secondary,
  output logic       bad,
  output logic       wclass
);
  always_comb begin
    primary   = RT_NONE;
    secondary = RT_NONE;
    bad       = 1'b0;
    if (llsc) begin
      primary   = wr ? RT_SC : RT_LL;
      secondary = RT_ATOMIC;
    end else if (locked) begin
      primary   = wr ? RT_LRMW_WR : RT_LRMW_RD;
      secondary = RT_ST;
    end else if (rd) begin
      if (ifetch) begin
        primary   = RT_IFETCH;
        secondary = RT_IFETCH;
      end else if (stchk) begin
        primary   = RT_RMW_RD;
        secondary = RT_ST;
      end else begin
        primary   = RT_LD;
        secondary = RT_LD;
      end
    end else if (wr) begin
      primary   = RT_ST;
      secondary = RT_ST;
    end else if (flush) begin
      primary   = RT_FLUSH;
      secondary = RT_FLUSH;
    end else begin
      bad = 1'b1;
    end
    wclass = !bad && !is_read_class(primary);
  end
endmodule

// File: rtl/line_table.sv
module line_table #(
  parameter int DEPTH     = 8,
  parameter int LINE_W    = 26,
  parameter int AGE_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] look_line,
  input  logic              ins_en,
  input  logic              rm_en,
  input  logic [LINE_W-1:0] rm_line,
  output logic              look_hit,
  output logic              rm_hit,
  output logic [DEPTH-1:0]  vld,
  output logic              stale
);
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);
  localparam logic [AGE_W-1:0] AGE_TOP = AGE_W'(AGE_LIMIT);

  logic [LINE_W-1:0] line_q [DEPTH];
  logic [AGE_W-1:0]  age_q  [DEPTH];
  logic [DEPTH-1:0]  look_m, rm_m, ins_sel, old_m;

  always_comb begin
    logic found;
    found   = 1'b0;
    ins_sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!vld[i] && !found) begin
        ins_sel[i] = 1'b1;
        found      = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign look_m[g] = vld[g] && (line_q[g] == look_line);
    assign rm_m[g]   = vld[g] && (line_q[g] == rm_line);
    assign old_m[g]  = vld[g] && (age_q[g] == AGE_TOP);

    always_ff @(posedge clk) begin
      if (rst) begin
        vld[g]    <= 1'b0;
        age_q[g]  <= '0;
        line_q[g] <= '0;
      end else if (rm_en && rm_m[g]) begin
        vld[g]   <= 1'b0;
        age_q[g] <= '0;
      end else if (ins_en && ins_sel[g]) begin
        vld[g]    <= 1'b1;
        line_q[g] <= look_line;
        age_q[g]  <= '0;
      end else if (vld[g] && age_q[g] != AGE_TOP) begin
        age_q[g] <= age_q[g] + 1'b1;
      end
    end
  end

  assign look_hit = |look_m;
  assign rm_hit   = |rm_m;
  assign stale    = |old_m;
endmodule

// File: rtl/mem_req_tracker.sv
module mem_req_tracker
  import trk_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 64,
  parameter int DEPTH      = 8,
  parameter int MAX_OUT    = 8,
  parameter int AGE_LIMIT  = 1000,
  parameter int CNT_W      = 16,
  localparam int OUT_W     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_rd,
  input  logic              req_wr,
  input  logic              req_flush,
  input  logic              req_llsc,
  input  logic              req_locked,
  input  logic              req_ifetch,
  input  logic              req_stchk,
  input  logic              cpl_valid,
  input  logic              cpl_write,
  input  logic [ADDR_W-1:0] cpl_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_status,
  output logic [3:0]        rsp_primary,
  output logic [3:0]        rsp_secondary,
  output logic [OUT_W-1:0]  outstanding,
  output logic              deadlock,
  output logic              cpl_err,
  output logic [CNT_W-1:0]  cnt_st_on_ld,
  output logic [CNT_W-1:0]  cnt_st_on_st,
  output logic [CNT_W-1:0]  cnt_ld_on_st,
  output logic [CNT_W-1:0]  cnt_ld_on_ld
);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = ADDR_W - OFF_W;

  logic [LINE_W-1:0] req_line, cpl_line;
  logic [3:0]        prim, sec;
  logic              bad, wclass, full, rd_hit, wr_hit, accept;
  logic              rd_rm_hit, wr_rm_hit, rd_rm, wr_rm, rd_old, wr_old;
  logic [DEPTH-1:0]  rd_vld, wr_vld;
  logic [1:0]        status;

  assign req_line = req_addr[ADDR_W-1:OFF_W];
  assign cpl_line = cpl_addr[ADDR_W-1:OFF_W];

  req_classifier u_cls (
    .rd(req_rd), .wr(req_wr), .flush(req_flush), .llsc(req_llsc),
    .locked(req_locked), .ifetch(req_ifetch), .stchk(req_stchk),
    .primary(prim), .secondary(sec), .bad(bad), .wclass(wclass)
  );

  assign full   = outstanding >= OUT_W'(MAX_OUT);
  assign accept = req_valid && !full && !bad && !rd_hit && !wr_hit;
  assign rd_rm  = cpl_valid && !cpl_write && rd_rm_hit;
  assign wr_rm  = cpl_valid && cpl_write && wr_rm_hit;

  line_table #(.DEPTH(DEPTH), .LINE_W(LINE_W), .AGE_LIMIT(AGE_LIMIT)) u_rd_tab (
    .clk(clk), .rst(rst), .look_line(req_line), .ins_en(accept && !wclass),
    .rm_en(cpl_valid && !cpl_write), .rm_line(cpl_line),
    .look_hit(rd_hit), .rm_hit(rd_rm_hit), .vld(rd_vld), .stale(rd_old)
  );

  line_table #(.DEPTH(DEPTH), .LINE_W(LINE_W), .AGE_LIMIT(AGE_LIMIT)) u_wr_tab (
    .clk(clk), .rst(rst), .look_line(req_line), .ins_en(accept && wclass),
    .rm_en(cpl_valid && cpl_write), .rm_line(cpl_line),
    .look_hit(wr_hit), .rm_hit(wr_rm_hit), .vld(wr_vld), .stale(wr_old)
  );

  always_comb begin
    if (full)                 status = SS_FULL;
    else if (bad)             status = SS_BADTYPE;
    else if (rd_hit || wr_hit) status = SS_ALIASED;
    else                      status = SS_ISSUED;
  end

  assign deadlock = rd_old || wr_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid     <= 1'b0;
      rsp_status    <= SS_ISSUED;
      rsp_primary   <= RT_NONE;
      rsp_secondary <= RT_NONE;
      outstanding   <= '0;
      cpl_err       <= 1'b0;
      cnt_st_on_ld  <= '0;
      cnt_st_on_st  <= '0;
      cnt_ld_on_st  <= '0;
      cnt_ld_on_ld  <= '0;
    end else begin
      rsp_valid     <= req_valid;
      rsp_status    <= status;
      rsp_primary   <= prim;
      rsp_secondary <= sec;
      outstanding   <= outstanding + OUT_W'(accept) - OUT_W'(rd_rm) - OUT_W'(wr_rm);
      cpl_err       <= cpl_valid && !(cpl_write ? wr_rm_hit : rd_rm_hit);
      if (req_valid && status == SS_ALIASED) begin
        if (wclass) begin
          if (rd_hit) begin
            if (cnt_st_on_ld != '1) cnt_st_on_ld <= cnt_st_on_ld + 1'b1;
          end else if (cnt_st_on_st != '1) cnt_st_on_st <= cnt_st_on_st + 1'b1;
        end else begin
          if (wr_hit) begin
            if (cnt_ld_on_st != '1) cnt_ld_on_st <= cnt_ld_on_st + 1'b1;
          end else if (cnt_ld_on_ld != '1) cnt_ld_on_ld <= cnt_ld_on_ld + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mem_req_tracker_chk.sv
module mem_req_tracker_chk #(
  parameter int DEPTH   = 8,
  parameter int MAX_OUT = 8,
  parameter int OUT_W   = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             cpl_valid,
  input logic             rsp_valid,
  input logic [1:0]       rsp_status,
  input logic [OUT_W-1:0] outstanding,
  input logic             deadlock,
  input logic             cpl_err,
  input logic [DEPTH-1:0] rd_vld,
  input logic [DEPTH-1:0] wr_vld
);
  // R11
  count_match_chk: assert property (@(posedge clk) disable iff (rst)
    32'(outstanding) == $countones(rd_vld) + $countones(wr_vld));

  // R2
  full_no_insert_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && 32'(outstanding) >= MAX_OUT && !cpl_valid)
    |=> (rsp_status == 2'd2 && outstanding == $past(outstanding)));

  // R6
  issue_grows_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd0 && !$past(cpl_valid))
    |-> outstanding == $past(outstanding) + 1'b1);

  // R3
  alias_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd1 && !$past(cpl_valid))
    |-> outstanding == $past(outstanding));

  // R9
  cpl_err_src_chk: assert property (@(posedge clk) disable iff (rst)
    cpl_err |-> $past(cpl_valid));

  // R10
  deadlock_live_chk: assert property (@(posedge clk) disable iff (rst)
    deadlock |-> outstanding != '0);
endmodule

bind mem_req_tracker mem_req_tracker_chk #(
  .DEPTH(DEPTH), .MAX_OUT(MAX_OUT), .OUT_W(OUT_W)
) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .cpl_valid(cpl_valid),
  .rsp_valid(rsp_valid), .rsp_status(rsp_status), .outstanding(outstanding),
  .deadlock(deadlock), .cpl_err(cpl_err), .rd_vld(rd_vld), .wr_vld(wr_vld)
);

// File: tb/mem_req_tracker_test.sv
module mem_req_tracker_test;
  localparam int AW = 8, LB = 4, DP = 4, MO = 4, AL = 20, CW = 8;
  localparam int OW = $clog2(MO + 1);

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 0, req_rd = 0, req_wr = 0, req_flush = 0, req_llsc = 0;
  logic req_locked = 0, req_ifetch = 0, req_stchk = 0;
  logic [AW-1:0] req_addr = '0, cpl_addr = '0;
  logic cpl_valid = 0, cpl_write = 0;
  logic rsp_valid, deadlock, cpl_err;
  logic [1:0] rsp_status;
  logic [3:0] rsp_primary, rsp_secondary;
  logic [OW-1:0] outstanding;
  logic [CW-1:0] c_sl, c_ss, c_ls, c_ll;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_req_tracker #(.ADDR_W(AW), .LINE_BYTES(LB), .DEPTH(DP), .MAX_OUT(MO),
    .AGE_LIMIT(AL), .CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_rd(req_rd), .req_wr(req_wr), .req_flush(req_flush), .req_llsc(req_llsc),
    .req_locked(req_locked), .req_ifetch(req_ifetch), .req_stchk(req_stchk),
    .cpl_valid(cpl_valid), .cpl_write(cpl_write), .cpl_addr(cpl_addr),
    .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_primary(rsp_primary),
    .rsp_secondary(rsp_secondary), .outstanding(outstanding), .deadlock(deadlock),
    .cpl_err(cpl_err), .cnt_st_on_ld(c_sl), .cnt_st_on_st(c_ss),
    .cnt_ld_on_st(c_ls), .cnt_ld_on_ld(c_ll));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flag bits: 0 rd, 1 wr, 2 flush, 3 llsc, 4 locked, 5 ifetch, 6 stchk
  task automatic send(input logic [6:0] f, input logic [AW-1:0] a);
    @(negedge clk);
    {req_stchk, req_ifetch, req_locked, req_llsc, req_flush, req_wr, req_rd} = f;
    req_addr = a; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic complete(input logic w, input logic [AW-1:0] a);
    @(negedge clk);
    cpl_valid = 1'b1; cpl_write = w; cpl_addr = a;
    @(negedge clk);
    cpl_valid = 1'b0;
  endtask

  function automatic void expect_cls(input logic [6:0] f, output int p, output int s,
                                     output int st);
    st = 0;
    if (f[3])      begin p = f[1] ? 6 : 5; s = 10; end
    else if (f[4]) begin p = f[1] ? 8 : 7; s = 2; end
    else if (f[0]) begin
      if (f[5])      begin p = 3; s = 3; end
      else if (f[6]) begin p = 4; s = 2; end
      else           begin p = 1; s = 1; end
    end
    else if (f[1]) begin p = 2; s = 2; end
    else if (f[2]) begin p = 9; s = 9; end
    else begin p = 0; s = 0; st = 3; end
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 outstanding", outstanding, 0);
    chk("R1 rsp_valid", rsp_valid, 0);
    chk("R1 deadlock", deadlock, 0);
    chk("R1 cpl_err", cpl_err, 0);
    chk("R1 counters", c_sl + c_ss + c_ls + c_ll, 0);

    // R7 R8 exhaustive sweep of the seven type flags
    for (int i = 0; i < 128; i++) begin
      int p, s, st;
      expect_cls(7'(i), p, s, st);
      send(7'(i), AW'(i));
      chk("R7/R8 status", rsp_status, st);
      chk("R7/R8 primary", rsp_primary, p);
      chk("R7/R8 secondary", rsp_secondary, s);
      if (st == 0) begin
        chk("R6 count after issue", outstanding, 1);
        complete(!(p == 1 || p == 3), AW'(i));
        chk("R9 cpl match", cpl_err, 0);
        chk("R9 count after cpl", outstanding, 0);
      end else chk("R8 bad type not inserted", outstanding, 0);
    end

    // R5 R6 load-behind-load using a different offset in the same line
    send(7'h01, 8'h40);
    chk("R6 load issued", rsp_status, 0);
    send(7'h01, 8'h43);
    chk("R5 load on load aliased", rsp_status, 1);
    chk("R5 ld_on_ld", c_ll, 1);
    send(7'h02, 8'h41);
    chk("R3 store on load aliased", rsp_status, 1);
    chk("R3 st_on_ld", c_sl, 1);
    chk("R3 count kept", outstanding, 1);
    complete(1'b0, 8'h40);
    send(7'h02, 8'h50);
    chk("R6 store issued", rsp_status, 0);
    send(7'h04, 8'h52);
    chk("R4 flush on store aliased", rsp_status, 1);
    chk("R4 st_on_st", c_ss, 1);
    send(7'h21, 8'h51);
    chk("R5 ifetch on store aliased", rsp_status, 1);
    chk("R5 ld_on_st", c_ls, 1);
    chk("R4 st_on_ld unchanged", c_sl, 1);
    complete(1'b1, 8'h50);
    chk("R9 freed", outstanding, 0);

    // R2 fill with two reads and two writes
    send(7'h01, 8'h00); send(7'h01, 8'h04);
    send(7'h02, 8'h08); send(7'h09, 8'h0C);
    chk("R11 full count", outstanding, 4);
    send(7'h01, 8'h10);
    chk("R2 full status", rsp_status, 2);
    chk("R2 nothing inserted", outstanding, 4);
    send(7'h00, 8'h14);
    chk("R2 full precedes bad type", rsp_status, 2);
    // R9 wrong table and unknown line
    complete(1'b1, 8'h00);
    chk("R9 wrong table err", cpl_err, 1);
    chk("R9 wrong table count", outstanding, 4);
    complete(1'b0, 8'h3C);
    chk("R9 unknown line err", cpl_err, 1);
    complete(1'b0, 8'h00); complete(1'b0, 8'h04);
    complete(1'b1, 8'h08); complete(1'b1, 8'h0C);
    chk("R9 drained", outstanding, 0);
    chk("R9 err clears", cpl_err, 0);
    send(7'h01, 8'h10);
    chk("R2 accepts after drain", rsp_status, 0);

    // R10 age boundary: entry inserted on the edge before this negedge
    repeat (AL - 1) @(negedge clk);
    chk("R10 below limit", deadlock, 0);
    @(negedge clk);
    chk("R10 at limit", deadlock, 1);
    complete(1'b0, 8'h10);
    chk("R10 cleared by completion", deadlock, 0);
    chk("R11 final count", outstanding, 0);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule